// File: doc/BRIEF.md
# Slot-Addressed Serial EEPROM Read Sequencer

This base-board block reads one 16-bit word from the serial configuration EEPROM on one of eight mezzanine slots. The EEPROM has no data-in wire of its own. Its data-in is the AND of bit 0 and bit 3 of a 4-bit module-ID bus shared by all slots, and each slot sees the driven code moved a slot-dependent number of steps along an eight-entry Johnson sequence. To send a serial bit, the sequencer picks the module-ID code that the target slot decodes as that bit.

A transaction sends a start bit, the read opcode and a six-bit address. It then reads back a dummy zero and sixteen data bits on a serial clock that is divided down from the system clock. The serial clock shares its wire with the JTAG clock, and the returned data shares its wire with JTAG data-out. The select line is held high for the whole transaction. On the mezzanine this forces the JTAG mode-select input high, so the JTAG state machine stays idle during the access.

A request is a one-cycle `start_i` together with a slot number and an address. The sequencer raises `busy_o` until the word is ready. It then pulses `done_o` and presents the word on `data_o`.

Top module: `eeprom_modid_reader`

## Requirements
- R1: After a synchronous active-low reset the block is idle: select low, serial clock low, module-ID bus 0x7, busy and done low. A reset during a transaction aborts it with the same result.
- R2: Each transaction delivers nine bits, MSB first, to the target slot's EEPROM data-in on successive serial clock rising edges: a start bit 1, the read opcode bits 1 then 0, then the six address bits.
- R3: The code sequence by index 0..7 is 0x7, 0x3, 0x1, 0x0, 0x8, 0xC, 0xE, 0xF. Slot k sees the code at index (i+k) mod 8 when index i is driven, and decodes data-in as bit0 AND bit3 of what it sees. A '1' bit for slot k is sent by driving index (7-k) mod 8, so slot k sees 0xF.
- R4: A '0' bit is sent by driving 0x7, or 0x3 when the target is slot 7. Every bit period after the nine request bits also carries the '0' code.
- R5: The tenth rising edge samples a dummy bit that is discarded. The next sixteen rising edges sample `ee_do_i` as data bits 15 down to 0, and that word appears on `data_o` in the cycle `done_o` is high.
- R6: While selected, the serial clock has a period of DIV system cycles: low for DIV/2 cycles, then high for DIV-DIV/2 cycles.
- R7: The module-ID bus and the select line change only at edges where the serial clock is low both before and after the edge.
- R8: The select line stays high from before the first rising edge until after the last serial clock falling edge of the transaction, and the serial clock is never high while the select is low.
- R9: Between two transactions the select line stays low for at least DIV system cycles.
- R10: `done_o` is a single-cycle pulse with `busy_o` low in that cycle. A `start_i` raised while `busy_o` is high is ignored: it changes neither the slot, the address nor the result, and starts no further transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted when idle |
| slot_i | input | 3 | Target mezzanine slot |
| addr_i | input | 6 | EEPROM word address |
| ee_do_i | input | 1 | Serial data returned by the EEPROM |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | 16 | Word read by the last transaction |
| ee_cs_o | output | 1 | EEPROM select |
| ee_sk_o | output | 1 | Serial clock, shared with the JTAG clock |
| modid_o | output | 4 | Module-ID bus that carries the serial data-in |

## Verification
The bench sweeps every slot against every address and decodes the module-ID bus on each rising edge the way each slot would. A wrong code-index step makes the target receive a corrupted request frame, and using 0x7 as the '0' code for slot 7 turns its zeros into ones. A one-edge slip in the sampling window shows up as a word shifted by one bit, with the dummy zero entering the MSB. It also aborts a transaction with reset, raises a request while busy, and runs transactions back to back, which catches a deselect gap shorter than a serial clock period and a module-ID change that lands while the clock is high.

// File: rtl/emr_pkg.sv
package emr_pkg;

  localparam int SEQ_LEN = 8;
  localparam int SLOT_W  = $clog2(SEQ_LEN);
  localparam int CODE_W  = 4;
  localparam int OPC_W   = 2;
  localparam logic [OPC_W-1:0] OPC_READ = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP
  } seq_state_e;

  // Johnson ring: entry index -> code
  function automatic logic [CODE_W-1:0] ring_code(input logic [SLOT_W-1:0] idx);
    logic [CODE_W-1:0] c;
    case (idx)
      3'd0:    c = 4'h7;
      3'd1:    c = 4'h3;
      3'd2:    c = 4'h1;
      3'd3:    c = 4'h0;
      3'd4:    c = 4'h8;
      3'd5:    c = 4'hC;
      3'd6:    c = 4'hE;
      default: c = 4'hF;
    endcase
    return c;
  endfunction

  // code -> entry index (codes off the ring map to 0)
  function automatic logic [SLOT_W-1:0] ring_index(input logic [CODE_W-1:0] code);
    logic [SLOT_W-1:0] i;
    case (code)
      4'h3:    i = 3'd1;
      4'h1:    i = 3'd2;
      4'h0:    i = 3'd3;
      4'h8:    i = 3'd4;
      4'hC:    i = 3'd5;
      4'hE:    i = 3'd6;
      4'hF:    i = 3'd7;
      default: i = 3'd0;
    endcase
    return i;
  endfunction

  // ring index that slot k must be sent to decode a '1'
  function automatic logic [SLOT_W-1:0] one_index(input logic [SLOT_W-1:0] slot);
    return SLOT_W'(SEQ_LEN - 1) - slot;
  endfunction

  // ring index for a '0': the bus idle value unless that is the '1' of the slot
  function automatic logic [SLOT_W-1:0] zero_index(input logic [SLOT_W-1:0] slot);
    return (slot == SLOT_W'(SEQ_LEN - 1)) ? SLOT_W'(1) : SLOT_W'(0);
  endfunction

  // value a given slot observes for a driven code
  function automatic logic [CODE_W-1:0] seen_code(input logic [CODE_W-1:0] code,
                                                  input logic [SLOT_W-1:0] slot);
    return ring_code(ring_index(code) + slot);
  endfunction

  // serial data-in decoded on the mezzanine
  function automatic logic decode_di(input logic [CODE_W-1:0] seen);
    return seen[0] & seen[3];
  endfunction

endpackage

// File: rtl/emr_sk_gen.sv
module emr_sk_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sk_en,
  output logic sk,
  output logic ev_load,
  output logic ev_sample,
  output logic ev_end
);
  localparam int DIV_EFF = (DIV < 4) ? 4 : DIV;
  localparam int HALF    = DIV_EFF / 2;
  localparam int CW      = $clog2(DIV_EFF + 1);

  logic [CW-1:0] cnt;

  assign ev_load   = run && (cnt == CW'(0));
  assign ev_sample = run && (cnt == CW'(HALF));
  assign ev_end    = run && (cnt == CW'(DIV_EFF - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      sk  <= 1'b0;
    end else begin
      cnt <= ev_end ? '0 : cnt + 1'b1;
      if (sk_en && cnt == CW'(HALF - 1)) sk <= 1'b1;
      else if (ev_end)                   sk <= 1'b0;
    end
  end

  // length of the current high and low runs of the serial clock
  logic [CW-1:0] hi_run;
  logic [CW-1:0] lo_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= CW'(HALF);
    end else begin
      hi_run <= sk ? hi_run + 1'b1 : '0;
      if (sk)                        lo_run <= '0;
      else if (lo_run != CW'(HALF))  lo_run <= lo_run + 1'b1;
    end
  end

  assert_sk_high_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sk) |-> hi_run == CW'(DIV_EFF - HALF));

  assert_sk_low_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sk) |-> lo_run == CW'(HALF));

endmodule

// File: rtl/emr_modid_enc.sv
module emr_modid_enc
  import emr_pkg::*;
(
  input  logic [SLOT_W-1:0] slot,
  input  logic              bit_val,
  input  logic              active,
  output logic [CODE_W-1:0] code
);
  always_comb begin
    if (!active)      code = ring_code(SLOT_W'(0));
    else if (bit_val) code = ring_code(one_index(slot));
    else              code = ring_code(zero_index(slot));
  end
endmodule

// File: rtl/emr_frame_ctrl.sv
module emr_frame_ctrl
  import emr_pkg::*;
#(
  parameter int DIV    = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOT_W-1:0] slot_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ee_do,
  input  logic              sk,
  input  logic              ev_load,
  input  logic              ev_sample,
  input  logic              ev_end,
  input  logic [CODE_W-1:0] code,
  output logic              run,
  output logic              sk_en,
  output logic              enc_active,
  output logic              tx_bit,
  output logic [SLOT_W-1:0] slot_q,
  output logic              cs,
  output logic [CODE_W-1:0] modid,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] data
);
  localparam int FRAME_W  = 1 + OPC_W + ADDR_W;
  localparam int RX_START = FRAME_W + 1;
  localparam int TOTAL    = FRAME_W + 1 + DATA_W;
  localparam int BW       = $clog2(TOTAL + 1);
  localparam int DIV_EFF  = (DIV < 4) ? 4 : DIV;
  localparam int GW       = $clog2(DIV_EFF + 1);

  seq_state_e        state;
  logic [BW-1:0]     bitn;
  logic [FRAME_W-1:0] tx;
  logic [DATA_W-1:0] rx;

  assign run        = (state != ST_IDLE);
  assign sk_en      = (state == ST_SHIFT);
  assign enc_active = (state == ST_SHIFT);
  assign tx_bit     = tx[FRAME_W-1];
  assign busy       = run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitn   <= '0;
      tx     <= '0;
      rx     <= '0;
      slot_q <= '0;
      cs     <= 1'b0;
      modid  <= ring_code(SLOT_W'(0));
      done   <= 1'b0;
      data   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_SHIFT;
            slot_q <= slot_in;
            tx     <= {1'b1, OPC_READ, addr_in};
            bitn   <= '0;
          end
        end
        ST_SHIFT: begin
          if (ev_load) begin
            cs    <= 1'b1;
            modid <= code;
          end
          if (ev_sample && bitn >= BW'(RX_START))
            rx <= {rx[DATA_W-2:0], ee_do};
          if (ev_end) begin
            tx <= tx << 1;
            if (bitn == BW'(TOTAL - 1)) state <= ST_GAP;
            else                        bitn  <= bitn + 1'b1;
          end
        end
        ST_GAP: begin
          if (ev_load) begin
            cs    <= 1'b0;
            modid <= code;
          end
          if (ev_end) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            data  <= rx;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // consecutive deselected cycles, saturating; reset counts as a full gap
  logic [GW-1:0] cs_low_run;
  always_ff @(posedge clk) begin
    if (!rst_n)                           cs_low_run <= GW'(DIV_EFF);
    else if (cs)                          cs_low_run <= '0;
    else if (cs_low_run != GW'(DIV_EFF))  cs_low_run <= cs_low_run + 1'b1;
  end

  assert_modid_sk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(modid) |-> !sk && !$past(sk));

  assert_cs_sk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs) |-> !sk && !$past(sk));

  assert_sk_needs_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sk |-> cs);

  assert_sample_while_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sample && state == ST_SHIFT) |-> sk && cs);

  assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !$past(cs)) |-> cs_low_run == GW'(DIV_EFF));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(slot_q));

endmodule

// File: rtl/eeprom_modid_reader.sv
module eeprom_modid_reader
  import emr_pkg::*;
#(
  parameter int DIV    = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ee_do_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ee_cs_o,
  output logic              ee_sk_o,
  output logic [CODE_W-1:0] modid_o
);
  logic              run, sk_en, enc_active, tx_bit;
  logic              ev_load, ev_sample, ev_end;
  logic [SLOT_W-1:0] slot_q;
  logic [CODE_W-1:0] next_code;

  emr_sk_gen #(.DIV(DIV)) u_sk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sk_en     (sk_en),
    .sk        (ee_sk_o),
    .ev_load   (ev_load),
    .ev_sample (ev_sample),
    .ev_end    (ev_end)
  );

  emr_modid_enc u_enc (
    .slot    (slot_q),
    .bit_val (tx_bit),
    .active  (enc_active),
    .code    (next_code)
  );

  emr_frame_ctrl #(.DIV(DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_i),
    .slot_in    (slot_i),
    .addr_in    (addr_i),
    .ee_do      (ee_do_i),
    .sk         (ee_sk_o),
    .ev_load    (ev_load),
    .ev_sample  (ev_sample),
    .ev_end     (ev_end),
    .code       (next_code),
    .run        (run),
    .sk_en      (sk_en),
    .enc_active (enc_active),
    .tx_bit     (tx_bit),
    .slot_q     (slot_q),
    .cs         (ee_cs_o),
    .modid      (modid_o),
    .busy       (busy_o),
    .done       (done_o),
    .data       (data_o)
  );

  // what each slot decodes from the bus right now
  logic [SEQ_LEN-1:0] slot_sees_one;
  for (genvar k = 0; k < SEQ_LEN; k++) begin : g_slot_view
    assign slot_sees_one[k] = decode_di(seen_code(modid_o, SLOT_W'(k)));
  end

  assert_one_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_cs_o && ee_sk_o && tx_bit) |-> slot_sees_one[slot_q]);

  assert_zero_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_cs_o && ee_sk_o && !tx_bit) |-> !slot_sees_one[slot_q]);

  assert_single_decoder_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ee_cs_o |-> $countones(slot_sees_one) == 1);

endmodule

// File: tb/eeprom_modid_reader_bench.sv
`timescale 1ns/1ps
module eeprom_modid_reader_bench;
  localparam int BDIV = 4;
  localparam int AW   = 6;
  localparam int DW   = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    slot = '0;
  logic [AW-1:0] addr = '0;
  logic          ee_do = 1'b0;
  logic          busy, done, cs, sk;
  logic [DW-1:0] data;
  logic [3:0]    modid;

  always #2.5 clk = ~clk;

  eeprom_modid_reader #(.DIV(BDIV), .ADDR_W(AW), .DATA_W(DW)) u_eeprom_modid_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start), .slot_i(slot), .addr_i(addr),
    .ee_do_i(ee_do), .busy_o(busy), .done_o(done), .data_o(data),
    .ee_cs_o(cs), .ee_sk_o(sk), .modid_o(modid)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Johnson ring computed by shifting
  function automatic logic [3:0] jcode(input int i);
    if (i < 4) return 4'(4'h7 >> i);
    return 4'(4'hF << (7 - i));
  endfunction

  function automatic int jindex(input logic [3:0] c);
    for (int j = 0; j < 8; j++) if (jcode(j) == c) return j;
    return -1;
  endfunction

  function automatic logic slot_di(input logic [3:0] c, input int s);
    int j;
    logic [3:0] v;
    j = jindex(c);
    if (j < 0) return 1'b0;
    v = jcode((j + s) % 8);
    return v[0] & v[3];
  endfunction

  function automatic logic [15:0] word_of(input int s, input int a);
    logic [2:0] s3;
    logic [5:0] a6;
    s3 = 3'(s);
    a6 = 6'(a);
    return {a6 ^ 6'h2A, s3, ~s3[0], a6};
  endfunction

  // EEPROM model and protocol monitors
  int tgt_slot = 0;
  int tgt_addr = 0;
  int rise_n = 0;
  int cyc = 0;
  int last_rise = 0;
  int last_fall_edge = 0;
  int cs_low = 0;
  bit had_txn = 1'b0;
  logic [8:0] got_frame;
  logic sk_q = 1'b0, cs_q = 1'b0, rst_q = 1'b0;
  logic [3:0] modid_q = 4'h7;
  bit bad_r2, bad_r3, bad_r4, bad_r6, bad_r7, bad_r8, bad_r9;
  int gap_seen = 0;

  task automatic clear_flags();
    bad_r2 = 0; bad_r3 = 0; bad_r4 = 0; bad_r6 = 0; bad_r7 = 0; bad_r8 = 0; bad_r9 = 0;
  endtask

  always @(negedge clk) begin
    logic [8:0] frame;
    logic fb, di;
    logic [3:0] want;
    logic [15:0] w;
    cyc++;
    if (!rst_n) begin
      rise_n = 0; had_txn = 0; cs_low = 0; ee_do = 1'b0;
    end else begin
      if (rst_q && (modid != modid_q || cs != cs_q) && (sk || sk_q)) bad_r7 = 1;
      if (sk && !cs) bad_r8 = 1;
      if (!cs && cs_q && rise_n != 26) bad_r8 = 1;
      if (cs && !cs_q) begin
        if (had_txn && cs_low < BDIV) begin bad_r9 = 1; gap_seen = cs_low; end
        had_txn = 1; rise_n = 0; got_frame = '0;
      end
      cs_low = cs ? 0 : cs_low + 1;
      if (sk && !sk_q) begin
        rise_n++;
        if (rise_n > 1 && cyc - last_rise != BDIV) bad_r6 = 1;
        last_rise = cyc;
        di = slot_di(modid, tgt_slot);
        frame = {1'b1, 2'b10, 6'(tgt_addr)};
        if (rise_n <= 9) begin
          fb = frame[9 - rise_n];
          got_frame = {got_frame[7:0], di};
          if (di != fb) bad_r2 = 1;
          if (fb) begin
            want = jcode((8 - 1 - tgt_slot) % 8);
            if (modid != want) bad_r3 = 1;
          end else begin
            want = (tgt_slot == 7) ? 4'h3 : 4'h7;
            if (modid != want) bad_r4 = 1;
          end
        end else begin
          want = (tgt_slot == 7) ? 4'h3 : 4'h7;
          if (modid != want || di) bad_r4 = 1;
        end
      end
      if (!sk && sk_q) begin
        if (cyc - last_rise != BDIV - BDIV / 2) bad_r6 = 1;
        w = word_of(tgt_slot, tgt_addr);
        if (rise_n == 9) ee_do = 1'b0;
        else if (rise_n >= 10 && rise_n <= 25) ee_do = w[25 - rise_n];
      end
    end
    sk_q = sk; cs_q = cs; modid_q = modid; rst_q = rst_n;
  end

  // one read; optional stray start while busy (slot/addr of the stray request given)
  task automatic do_read(input int s, input int a, input bit stray, input int ss, input int sa);
    int waited;
    clear_flags();
    tgt_slot = s; tgt_addr = a;
    @(negedge clk);
    start = 1'b1; slot = 3'(s); addr = 6'(a);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 busy after start", busy, 1);
    waited = 0;
    while (!done && waited < 60 * BDIV) begin
      @(negedge clk);
      waited++;
      if (stray && waited == 20) begin start = 1'b1; slot = 3'(ss); addr = 6'(sa); end
      if (stray && waited == 21) start = 1'b0;
    end
    check(done == 1'b1, "R10 done reached", done, 1);
    check(data == word_of(s, a), "R5 data word", data, word_of(s, a));
    check(busy == 1'b0, "R10 busy low with done", busy, 0);
    check(!bad_r2, "R2 frame at target", got_frame, {1'b1, 2'b10, 6'(a)});
    check(!bad_r3, "R3 one code", s, s);
    check(!bad_r4, "R4 zero code", s, s);
    check(!bad_r6, "R6 clock shape", 1, 0);
    check(!bad_r7, "R7 change while low", 1, 0);
    check(!bad_r8, "R8 select span", 1, 0);
    check(!bad_r9, "R9 deselect gap", gap_seen, BDIV);
    @(negedge clk);
    check(done == 1'b0, "R10 done single pulse", done, 0);
  endtask

  task automatic check_idle(input string tag);
    check(cs == 1'b0, tag, cs, 0);
    check(sk == 1'b0, tag, sk, 0);
    check(modid == 4'h7, tag, modid, 7);
    check(busy == 1'b0 && done == 1'b0, tag, {busy, done}, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check_idle("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 idle after reset");

    // exhaustive slot x address sweep, back to back
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 64; a++)
        do_read(s, a, 1'b0, 0, 0);

    // request during busy must be ignored
    do_read(2, 5, 1'b1, 6, 33);
    repeat (3 * BDIV) @(negedge clk);
    check(busy == 1'b0 && cs == 1'b0, "R10 stray start started nothing", {busy, cs}, 0);
    check(data == word_of(2, 5), "R10 result kept", data, word_of(2, 5));

    // abort with reset mid-transaction
    tgt_slot = 4; tgt_addr = 17;
    @(negedge clk);
    start = 1'b1; slot = 3'd4; addr = 6'd17;
    @(negedge clk);
    start = 1'b0;
    repeat (13) @(negedge clk);
    rst_n = 1'b0;
    repeat (BDIV + 2) @(negedge clk);
    check_idle("R1 abort by reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 idle after abort");
    do_read(7, 63, 1'b0, 0, 0);
    do_read(0, 0, 1'b0, 0, 0);

    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_up();
  end

endmodule